// File: doc/BRIEF.md
# SMM Halt Restart Sequencer

This block tracks the power state of a simple processor core as it moves between normal execution, halt and system-management mode. When a management interrupt arrives, the block records in a 16-bit state-save slot whether the core was halted at that moment. The management service routine can read that record and overwrite it. When the routine issues a resume, the slot decides where the core goes next. It either resumes instruction fetch from the saved context, or it returns to halt without refetching the halt instruction.

The core's decoder reports a halt instruction on `halt_cmd`. The interrupt logic raises `smi_in`, and the service routine's resume instruction pulses `resume`. The slot is accessed through a single-cycle write port and a continuously valid read port. Each time the core enters halt, the block emits a one-cycle halt bus-cycle strobe. It also gates instruction fetch.

Top module: `smm_halt_seq`

## Requirements
- R1: A synchronous active-high reset puts the block in the running state: `fetch_en`=1, `halt_cycle`=0 and `slot_rdata`=16'h0000, visible after the first clock edge with reset high.
- R2: `halt_cmd` while running, with `smi_in` low, moves the core to halt. After that edge `fetch_en` is 0, and `halt_cycle` is 1 for exactly one cycle.
- R3: `halt_cmd` while halted or in management mode has no effect: no `halt_cycle` pulse, and `fetch_en` stays 0.
- R4: `smi_in` while running or halted enters management mode, with `fetch_en`=0. Slot bit 0 becomes 1 if the core was halted and 0 if it was running. When `smi_in` and `halt_cmd` arrive together while running, `smi_in` wins and no strobe is produced.
- R5: Entry into management mode changes only slot bit 0. Bits 15..1 keep the value last written.
- R6: `slot_we` in management mode stores all 16 bits of `slot_wdata`, which show on `slot_rdata` after that edge. `slot_we` outside management mode is ignored. A write in the same cycle as `resume` is stored, but the exit decision uses the value held before that write.
- R7: `resume` in management mode with slot bit 0 = 1 returns the core to halt. It produces one `halt_cycle` pulse and keeps `fetch_en` at 0.
- R8: `resume` in management mode with slot bit 0 = 0 returns the core to running. `fetch_en` becomes 1 and there is no `halt_cycle` pulse.
- R9: `smi_in` while in management mode is ignored: the block stays in management mode and the slot is unchanged. `resume` outside management mode is ignored.
- R10: Slot bits 15..1 have no effect on the exit decision.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst | input | 1 | Synchronous active-high reset |
| halt_cmd | input | 1 | Halt instruction executed |
| smi_in | input | 1 | Management interrupt request |
| resume | input | 1 | Return from management mode |
| slot_we | input | 1 | Slot write strobe |
| slot_wdata | input | 16 | Slot write data |
| slot_rdata | output | 16 | Current slot contents |
| halt_cycle | output | 1 | One-cycle halt bus-cycle strobe |
| fetch_en | output | 1 | Instruction fetch enable |

## Verification
A wrong internal state shows at the ports within one cycle. If the sequencer wrongly believes it is running, `fetch_en` is raised while the core should be halted or in management mode. A wrong entry latch shows on slot bit 0 right after the interrupt edge, and a wrong exit decision shows on `fetch_en` and `halt_cycle` right after the resume edge. A state wrongly left as management mode is exposed by a slot write that should be ignored but lands.

// File: rtl/smm_halt_seq.sv
module smm_halt_seq (
  input  logic        clk,
  input  logic        rst,
  input  logic        halt_cmd,
  input  logic        smi_in,
  input  logic        resume,
  input  logic        slot_we,
  input  logic [15:0] slot_wdata,
  output logic [15:0] slot_rdata,
  output logic        halt_cycle,
  output logic        fetch_en
);

  typedef enum logic [1:0] {S_RUN, S_HALT, S_SMM} state_t;

  state_t      state;
  logic [15:0] slot_q;
  logic        pulse_q;

  wire in_smm    = (state == S_SMM);
  wire enter_smm = !in_smm && smi_in;
  wire go_halt   = (state == S_RUN) && !smi_in && halt_cmd;
  wire exit_smm  = in_smm && resume;

  always_ff @(posedge clk) begin
    if (rst) begin
      state   <= S_RUN;
      slot_q  <= '0;
      pulse_q <= 1'b0;
    end else begin
      pulse_q <= go_halt || (exit_smm && slot_q[0]);
      if (in_smm && slot_we)
        slot_q <= slot_wdata;
      else if (enter_smm)
        slot_q[0] <= (state == S_HALT);
      case (state)
        S_RUN:   if (smi_in) state <= S_SMM; else if (halt_cmd) state <= S_HALT;
        S_HALT:  if (smi_in) state <= S_SMM;
        S_SMM:   if (resume) state <= slot_q[0] ? S_HALT : S_RUN;
        default: state <= S_RUN;
      endcase
    end
  end

  assign slot_rdata = slot_q;
  assign halt_cycle = pulse_q;
  assign fetch_en   = (state == S_RUN);

  p_pulse_single_r2: assert property (@(posedge clk) disable iff (rst)
    halt_cycle |=> !halt_cycle);
  p_pulse_nofetch_r2: assert property (@(posedge clk) disable iff (rst)
    halt_cycle |-> !fetch_en);
  p_entry_latch_r4: assert property (@(posedge clk) disable iff (rst)
    enter_smm |=> in_smm && !fetch_en && (slot_rdata[0] == ($past(state) == S_HALT)));
  p_entry_upper_r5: assert property (@(posedge clk) disable iff (rst)
    enter_smm |=> slot_rdata[15:1] == $past(slot_rdata[15:1]));
  p_write_smm_r6: assert property (@(posedge clk) disable iff (rst)
    (in_smm && slot_we) |=> slot_rdata == $past(slot_wdata));
  p_write_ignored_r6: assert property (@(posedge clk) disable iff (rst)
    (!in_smm && !smi_in) |=> $stable(slot_rdata));
  p_exit_halt_r7: assert property (@(posedge clk) disable iff (rst)
    (exit_smm && slot_q[0]) |=> halt_cycle && !fetch_en);
  p_exit_run_r8: assert property (@(posedge clk) disable iff (rst)
    (exit_smm && !slot_q[0]) |=> fetch_en && !halt_cycle);
  p_smm_hold_r9: assert property (@(posedge clk) disable iff (rst)
    (in_smm && !resume) |=> in_smm && !fetch_en);

endmodule

// File: tb/smm_halt_seq_tb_top.sv
module smm_halt_seq_tb_top;
  logic clk = 1'b0;
  logic rst, halt_cmd, smi_in, resume, slot_we;
  logic [15:0] slot_wdata, slot_rdata;
  logic halt_cycle, fetch_en;
  int checks = 0, fails = 0;
  bit done = 1'b0;

  always #5 clk = ~clk;

  smm_halt_seq dut_i (
    .clk(clk), .rst(rst), .halt_cmd(halt_cmd), .smi_in(smi_in), .resume(resume),
    .slot_we(slot_we), .slot_wdata(slot_wdata), .slot_rdata(slot_rdata),
    .halt_cycle(halt_cycle), .fetch_en(fetch_en)
  );

  // {req[41:38], smi, halt, resume, we, wdata[15:0], exp_fetch, exp_pulse, exp_rdata[15:0]}
  localparam int NV = 21;
  localparam logic [41:0] VEC [NV] = '{
    {4'd1,  4'b0000, 16'h0000, 2'b10, 16'h0000}, // R1 idle after reset
    {4'd2,  4'b0100, 16'h0000, 2'b01, 16'h0000}, // R2 halt from run
    {4'd2,  4'b0000, 16'h0000, 2'b00, 16'h0000}, // R2 pulse single
    {4'd3,  4'b0100, 16'h0000, 2'b00, 16'h0000}, // R3 halt while halted
    {4'd4,  4'b1000, 16'h0000, 2'b00, 16'h0001}, // R4 smi from halt
    {4'd9,  4'b1000, 16'h0000, 2'b00, 16'h0001}, // R9 smi in smm
    {4'd6,  4'b0001, 16'hAAA4, 2'b00, 16'hAAA4}, // R6 write in smm
    {4'd6,  4'b0001, 16'hFFFF, 2'b00, 16'hFFFF}, // R6 write all ones
    {4'd7,  4'b0010, 16'h0000, 2'b01, 16'hFFFF}, // R7 resume to halt
    {4'd7,  4'b0000, 16'h0000, 2'b00, 16'hFFFF}, // R7 pulse single
    {4'd6,  4'b0001, 16'h1234, 2'b00, 16'hFFFF}, // R6 write in halt ignored
    {4'd5,  4'b1000, 16'h0000, 2'b00, 16'hFFFF}, // R5 smi from halt keeps upper
    {4'd6,  4'b0001, 16'h5556, 2'b00, 16'h5556}, // R6 bit0 cleared, upper set
    {4'd10, 4'b0010, 16'h0000, 2'b10, 16'h5556}, // R10 R8 resume to run
    {4'd9,  4'b0010, 16'h0000, 2'b10, 16'h5556}, // R9 resume in run ignored
    {4'd4,  4'b1100, 16'h0000, 2'b00, 16'h5556}, // R4 smi beats halt, bit0=0
    {4'd3,  4'b0100, 16'h0000, 2'b00, 16'h5556}, // R3 halt in smm
    {4'd6,  4'b0011, 16'h0001, 2'b10, 16'h0001}, // R6 write with resume uses old bit
    {4'd2,  4'b0100, 16'h0000, 2'b01, 16'h0001}, // R2 halt again
    {4'd4,  4'b1000, 16'h0000, 2'b00, 16'h0001}, // R4 smi from halt sets bit0
    {4'd7,  4'b0010, 16'h0000, 2'b01, 16'h0001}  // R7 resume to halt
  };

  task automatic check(input string req, input logic [17:0] act, input logic [17:0] exp);
    checks++;
    if (act !== exp) begin
      fails++;
      $display("FAIL %s fetch/pulse/rdata actual=%b_%b_%h expected=%b_%b_%h",
               req, act[17], act[16], act[15:0], exp[17], exp[16], exp[15:0]);
    end
  endtask

  task automatic idle_inputs();
    {smi_in, halt_cmd, resume, slot_we} = 4'b0000;
    slot_wdata = 16'h0000;
  endtask

  initial begin
    rst = 1'b1;
    idle_inputs();
    @(negedge clk); @(negedge clk);
    check("R1", {fetch_en, halt_cycle, slot_rdata}, {2'b10, 16'h0000});
    rst = 1'b0;
    for (int i = 0; i < NV; i++) begin
      @(negedge clk);
      {smi_in, halt_cmd, resume, slot_we} = VEC[i][37:34];
      slot_wdata = VEC[i][33:18];
      @(posedge clk); #1;
      check($sformatf("R%0d", VEC[i][41:38]), {fetch_en, halt_cycle, slot_rdata}, VEC[i][17:0]);
    end
    // R1: reset from halt with a nonzero slot
    @(negedge clk);
    idle_inputs();
    rst = 1'b1;
    @(posedge clk); #1;
    check("R1", {fetch_en, halt_cycle, slot_rdata}, {2'b10, 16'h0000});
    @(negedge clk);
    rst = 1'b0;
    // R5 R10: enter from run with upper bits set, resume stays run
    smi_in = 1'b1;
    @(posedge clk); #1;
    check("R4", {fetch_en, halt_cycle, slot_rdata}, {2'b00, 16'h0000});
    @(negedge clk);
    smi_in = 1'b0; slot_we = 1'b1; slot_wdata = 16'hFFFE;
    @(posedge clk); #1;
    check("R6", {fetch_en, halt_cycle, slot_rdata}, {2'b00, 16'hFFFE});
    @(negedge clk);
    slot_we = 1'b0; resume = 1'b1;
    @(posedge clk); #1;
    check("R10", {fetch_en, halt_cycle, slot_rdata}, {2'b10, 16'hFFFE});
    @(negedge clk);
    resume = 1'b0; smi_in = 1'b1;
    @(posedge clk); #1;
    check("R5", {fetch_en, halt_cycle, slot_rdata}, {2'b00, 16'hFFFE});
    @(negedge clk);
    idle_inputs();
    done = 1'b1;
  end

  initial begin
    fork
      wait (done);
      begin
        repeat (5000) @(posedge clk);
        checks++; fails++;
        $display("FAIL watchdog expired");
      end
    join_any
    $display("TB_RESULT checks=%0d failures=%0d", checks, fails);
    $finish;
  end
endmodule